// File: doc/BRIEF.md
# Quadrant-Threaded DRAM Bank Controller

This block is the command-side controller of a DRAM core whose sixteen banks are split into four quadrants of four banks. Each quadrant has its own row circuitry and its own column circuitry, so rows and columns in different quadrants can be worked at the same time. The block takes row-activate and column commands, each naming a bank. It decides in the same cycle whether the command meets the quadrant timing and bank-state rules. Every rejected command produces a one-cycle error pulse and changes no state.

An accepted column drives data for half of a column interval only. The data bus is cut into half-interval slots that alternate between half 0 and half 1. The other half of each interval is left for a column from a different quadrant, so columns from several quadrants interleave on the pins. Even banks use pin group A and odd banks use pin group B. The outputs show, for each cycle, whether data is on the pins, which group carries it, which bank and column it belongs to, and which half-slot is running.

The quadrant number is bank bits [3:2]. Bank bits [1:0] pick the bank inside the quadrant. Each quadrant has a row timer with states ROW_READY and ROW_WAIT, and a column timer with states COL_READY and COL_WAIT. An accepted command moves its timer from READY to WAIT, and the timer returns to READY when its count expires. The slot sequencer has a reservation machine with states RSV_NONE and RSV_HELD. A column accept moves it from RSV_NONE to RSV_HELD, and a slot boundary moves it back to RSV_NONE. Its bus machine has states BUS_IDLE and BUS_DRIVE. At each slot boundary the bus machine enters BUS_DRIVE if a reservation is held, and BUS_IDLE otherwise.

Top module: `qbc_top`

## Requirements
- R1: While reset is asserted, every output is 0. After reset all banks are closed, so a column command to any bank is rejected, and all quadrant timers are ready.
- R2: An activate (cmd_is_col = 0) is accepted when its quadrant (bank bits [3:2]) has an expired row timer. Otherwise it is rejected.
- R3: After an activate is accepted at clock edge t, the next activate in the same quadrant is rejected up to edge t+2*COL_CYC-1 and accepted from edge t+2*COL_CYC.
- R4: Commands to other quadrants are not held back by a running row or column timer of a different quadrant.
- R5: An accepted activate gives its bank exactly two column accesses. A column command (cmd_is_col = 1) to a bank with no accesses left, or to a bank never activated since reset, is rejected.
- R6: After a column is accepted at edge t, another column in the same quadrant is rejected up to edge t+COL_CYC-1.
- R7: The data bus runs in slots of COL_CYC/2 cycles. Slot boundaries fall on the edges numbered COL_CYC/2, COL_CYC, ... counted from reset release. dq_half is 0 in the first slot and alternates at each boundary.
- R8: An accepted column appears on the data outputs for exactly the first full slot that starts after its accept edge. During that slot, dq_valid = 1, dq_bank and dq_col are the command's values, and dq_grp is bank bit 0 (0 = group A, 1 = group B). In slots with no data, dq_valid, dq_grp, dq_bank and dq_col are 0.
- R9: Only one column may claim a slot. A column that arrives while an earlier column is still waiting for its slot is rejected. The one exception is an arrival on the boundary edge itself, which is accepted.
- R10: The two halves of any column interval (a half-0 slot and the half-1 slot after it) never carry data from the same quadrant.
- R11: cmd_err is high for exactly the one cycle after the edge at which a rejected command was sampled. A rejected command changes no timer, credit or reservation.
- R12: When cmd_valid is 0, the other command inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_is_col | input | 1 | 1 = column access, 0 = row activate |
| cmd_bank | input | 4 | Target bank; [3:2] quadrant, [0] pin group |
| cmd_col | input | COL_W | Column address of a column command |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |
| dq_valid | output | 1 | Data present on the pins this cycle |
| dq_grp | output | 1 | Active pin group (0 = A, 1 = B) |
| dq_bank | output | 4 | Bank whose data is on the pins |
| dq_col | output | COL_W | Column address whose data is on the pins |
| dq_half | output | 1 | Half-slot index within the column interval |

## Verification
cmd_err is registered, so it is due in the cycle after the edge that sampled the command. The bench drives each command on a falling edge and reads cmd_err at the next falling edge. Column data is due at the first slot boundary after the accept edge, which is one to COL_CYC/2 edges later, and it then holds for COL_CYC/2 cycles. For this reason the expected-value table lists the data outputs for every cycle, computed from the boundary edge numbers that R7 gives. The bench checks the interleave rule from the outputs alone: it records the quadrant in each half-0 slot and compares it with the quadrant of the half-1 slot that follows.

// File: rtl/qbc_pkg.sv
package qbc_pkg;
    localparam int NUM_BANKS      = 16;
    localparam int NUM_QUADS      = 4;
    localparam int BANK_W         = $clog2(NUM_BANKS);
    localparam int QUAD_W         = $clog2(NUM_QUADS);
    localparam int BANKS_PER_QUAD = NUM_BANKS / NUM_QUADS;
    localparam int SUB_W          = $clog2(BANKS_PER_QUAD);
    localparam int COLS_PER_ROW   = 2;

    typedef enum logic { ROW_READY, ROW_WAIT } row_state_t;
    typedef enum logic { COL_READY, COL_WAIT } col_state_t;
    typedef enum logic { RSV_NONE, RSV_HELD } rsv_state_t;
    typedef enum logic { BUS_IDLE, BUS_DRIVE } bus_state_t;
endpackage

// File: rtl/qbc_quad_ctl.sv
module qbc_quad_ctl
    import qbc_pkg::*;
#(
    parameter int COL_CYC = 4,
    parameter int BPQ     = 4,
    parameter int SW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_go,
    input  logic          col_go,
    input  logic [SW-1:0] sel,
    output logic          act_ok,
    output logic          col_ok
);
    localparam int ROW_CYC = 2 * COL_CYC;
    localparam int RW      = $clog2(ROW_CYC);
    localparam int CW      = $clog2(COL_CYC);

    row_state_t    row_st, row_nx;
    col_state_t    col_st, col_nx;
    logic [RW-1:0] row_cnt;
    logic [CW-1:0] col_cnt;
    logic [1:0]    credit [BPQ];

    // row timer state
    always_comb begin
        row_nx = row_st;
        unique case (row_st)
            ROW_READY: if (act_go) row_nx = ROW_WAIT;
            ROW_WAIT:  if (row_cnt == RW'(1)) row_nx = ROW_READY;
        endcase
    end

    // column timer state
    always_comb begin
        col_nx = col_st;
        unique case (col_st)
            COL_READY: if (col_go) col_nx = COL_WAIT;
            COL_WAIT:  if (col_cnt == CW'(1)) col_nx = COL_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_st <= ROW_READY;
            col_st <= COL_READY;
        end else begin
            row_st <= row_nx;
            col_st <= col_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_cnt <= '0;
            col_cnt <= '0;
        end else begin
            if (act_go)              row_cnt <= RW'(ROW_CYC - 1);
            else if (row_cnt != '0)  row_cnt <= row_cnt - RW'(1);
            if (col_go)              col_cnt <= CW'(COL_CYC - 1);
            else if (col_cnt != '0)  col_cnt <= col_cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < BPQ; b++) credit[b] <= 2'd0;
        end else if (act_go) begin
            credit[sel] <= 2'(COLS_PER_ROW);
        end else if (col_go) begin
            credit[sel] <= credit[sel] - 2'd1;
        end
    end

    always_comb begin
        act_ok = (row_st == ROW_READY);
        col_ok = (col_st == COL_READY) && (credit[sel] != 2'd0);
    end

    // R3: the ready state and the countdown agree
    assert_row_ready_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_st == ROW_READY) |-> (row_cnt == '0));
    // R3: a running row timer counts down by one each cycle
    assert_row_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_cnt != '0) |=> (row_cnt == $past(row_cnt) - RW'(1)));
    // R6: a running column timer blocks column acceptance
    assert_col_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (col_cnt != '0) |-> !col_go);

    generate
        for (genvar g = 0; g < BPQ; g++) begin : g_credit_chk
            // R5: never more than two accesses per activated row
            assert_credit_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
                credit[g] <= 2'(COLS_PER_ROW));
        end
    endgenerate
endmodule

// File: rtl/qbc_slot_seq.sv
module qbc_slot_seq
    import qbc_pkg::*;
#(
    parameter int HALF  = 2,
    parameter int BW    = 4,
    parameter int QW    = 2,
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             col_go,
    input  logic [BW-1:0]    go_bank,
    input  logic [COL_W-1:0] go_col,
    output logic             slot_free,
    output logic             dq_valid,
    output logic [BW-1:0]    dq_bank,
    output logic [COL_W-1:0] dq_col,
    output logic             dq_half
);
    localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;

    rsv_state_t       rsv_st, rsv_nx;
    bus_state_t       bus_st, bus_nx;
    logic [PW-1:0]    phase;
    logic             wrap;
    logic [BW-1:0]    rsv_bank;
    logic [COL_W-1:0] rsv_col;

    assign wrap = (phase == PW'(HALF - 1));

    always_comb begin
        rsv_nx = rsv_st;
        unique case (rsv_st)
            RSV_NONE: if (col_go) rsv_nx = RSV_HELD;
            RSV_HELD: if (wrap)   rsv_nx = col_go ? RSV_HELD : RSV_NONE;
        endcase
    end

    always_comb begin
        bus_nx = bus_st;
        if (wrap) begin
            unique case (rsv_st)
                RSV_NONE: bus_nx = BUS_IDLE;
                RSV_HELD: bus_nx = BUS_DRIVE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsv_st <= RSV_NONE;
            bus_st <= BUS_IDLE;
        end else begin
            rsv_st <= rsv_nx;
            bus_st <= bus_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= '0;
            dq_half  <= 1'b0;
            rsv_bank <= '0;
            rsv_col  <= '0;
            dq_bank  <= '0;
            dq_col   <= '0;
        end else begin
            phase <= wrap ? '0 : phase + PW'(1);
            if (wrap) dq_half <= ~dq_half;
            if (col_go) begin
                rsv_bank <= go_bank;
                rsv_col  <= go_col;
            end
            if (wrap) begin
                dq_bank <= (rsv_st == RSV_HELD) ? rsv_bank : '0;
                dq_col  <= (rsv_st == RSV_HELD) ? rsv_col  : '0;
            end
        end
    end

    always_comb begin
        slot_free = (rsv_st == RSV_NONE) || wrap;
        dq_valid  = (bus_st == BUS_DRIVE);
    end

    // checker state: occupant of the slot before the current one
    logic          prev_valid;
    logic [QW-1:0] prev_quad;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_valid <= 1'b0;
            prev_quad  <= '0;
        end else if (wrap) begin
            prev_valid <= dq_valid;
            prev_quad  <= dq_bank[BW-1 -: QW];
        end
    end

    // R10: both halves of one column interval come from different quadrants
    assert_halves_distinct_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && dq_half && prev_valid) |-> (prev_quad != dq_bank[BW-1 -: QW]));
    // R7: data outputs change only on slot boundaries
    assert_slot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wrap) |-> ($stable(dq_valid) && $stable(dq_bank) && $stable(dq_half)));
    // R8: a held reservation is driven in the next slot
    assert_rsv_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_st == RSV_HELD && wrap) |=> (dq_valid && dq_bank == $past(rsv_bank)));
    // R9: no column is accepted over an unconsumed reservation
    assert_single_claim_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_st == RSV_HELD && !wrap) |-> !col_go);
endmodule

// File: rtl/qbc_top.sv
module qbc_top
    import qbc_pkg::*;
#(
    parameter int COL_CYC = 4,
    parameter int COL_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_is_col,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    output logic              cmd_err,
    output logic              dq_valid,
    output logic              dq_grp,
    output logic [BANK_W-1:0] dq_bank,
    output logic [COL_W-1:0]  dq_col,
    output logic              dq_half
);
    localparam int HALF = COL_CYC / 2;

    logic [QUAD_W-1:0]    cmd_quad;
    logic [SUB_W-1:0]     cmd_sub;
    logic [NUM_QUADS-1:0] act_ok, col_ok, act_go, col_go;
    logic                 slot_free, accept;

    assign cmd_quad = cmd_bank[BANK_W-1 -: QUAD_W];
    assign cmd_sub  = cmd_bank[SUB_W-1:0];

    generate
        for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
            logic hit;
            assign hit       = cmd_valid && (cmd_quad == QUAD_W'(q));
            assign act_go[q] = hit && !cmd_is_col && act_ok[q];
            assign col_go[q] = hit &&  cmd_is_col && col_ok[q] && slot_free;

            qbc_quad_ctl #(
                .COL_CYC (COL_CYC),
                .BPQ     (BANKS_PER_QUAD),
                .SW      (SUB_W)
            ) u_quad (
                .clk    (clk),
                .rst_n  (rst_n),
                .act_go (act_go[q]),
                .col_go (col_go[q]),
                .sel    (cmd_sub),
                .act_ok (act_ok[q]),
                .col_ok (col_ok[q])
            );
        end
    endgenerate

    qbc_slot_seq #(
        .HALF  (HALF),
        .BW    (BANK_W),
        .QW    (QUAD_W),
        .COL_W (COL_W)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_go    (|col_go),
        .go_bank   (cmd_bank),
        .go_col    (cmd_col),
        .slot_free (slot_free),
        .dq_valid  (dq_valid),
        .dq_bank   (dq_bank),
        .dq_col    (dq_col),
        .dq_half   (dq_half)
    );

    assign accept = (|act_go) || (|col_go);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_err <= 1'b0;
        else        cmd_err <= cmd_valid && !accept;
    end

    assign dq_grp = dq_valid && dq_bank[0];

    // R11: an error pulse always follows a presented command
    assert_err_after_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_valid));
    // R2: at most one quadrant accepts a command per cycle
    assert_one_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_go, col_go}));
    // R12: nothing is accepted without a valid command
    assert_idle_no_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !cmd_err);
endmodule

// File: tb/tb_qbc_top.sv
module tb_qbc_top;
    localparam int NV = 23;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_is_col = 1'b0;
    logic [3:0] cmd_bank = '0;
    logic [7:0] cmd_col = '0;
    logic       cmd_err, dq_valid, dq_grp, dq_half;
    logic [3:0] dq_bank;
    logic [7:0] dq_col;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    qbc_top #(.COL_CYC(4), .COL_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_col(cmd_is_col),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_err(cmd_err),
        .dq_valid(dq_valid), .dq_grp(dq_grp), .dq_bank(dq_bank),
        .dq_col(dq_col), .dq_half(dq_half)
    );

    // {valid, is_col, bank, col, exp err, exp dq_valid, exp bank, exp col, exp half, exp grp}
    // entry k is sampled at edge k+1 after reset release; slot length 2, boundaries at even edges
    localparam logic [29:0] VEC [NV] = '{
        {1'b1,1'b0,4'd0,8'h00, 1'b0,1'b0,4'd0,8'h00,1'b0,1'b0},
        {1'b1,1'b0,4'd5,8'h00, 1'b0,1'b0,4'd0,8'h00,1'b1,1'b0},
        {1'b1,1'b0,4'd1,8'h00, 1'b1,1'b0,4'd0,8'h00,1'b1,1'b0},
        {1'b1,1'b1,4'd0,8'h11, 1'b0,1'b0,4'd0,8'h00,1'b0,1'b0},
        {1'b1,1'b1,4'd5,8'h22, 1'b1,1'b0,4'd0,8'h00,1'b0,1'b0},
        {1'b1,1'b1,4'd5,8'h22, 1'b0,1'b1,4'd0,8'h11,1'b1,1'b0},
        {1'b1,1'b1,4'd0,8'h66, 1'b1,1'b1,4'd0,8'h11,1'b1,1'b0},
        {1'b1,1'b1,4'd0,8'h33, 1'b0,1'b1,4'd5,8'h22,1'b0,1'b1},
        {1'b1,1'b0,4'd1,8'h00, 1'b0,1'b1,4'd5,8'h22,1'b0,1'b1},
        {1'b1,1'b1,4'd0,8'h77, 1'b1,1'b1,4'd0,8'h33,1'b1,1'b0},
        {1'b1,1'b1,4'd1,8'h44, 1'b1,1'b1,4'd0,8'h33,1'b1,1'b0},
        {1'b1,1'b1,4'd1,8'h44, 1'b0,1'b0,4'd0,8'h00,1'b0,1'b0},
        {1'b0,1'b1,4'd3,8'h99, 1'b0,1'b0,4'd0,8'h00,1'b0,1'b0},
        {1'b1,1'b1,4'd1,8'h55, 1'b1,1'b1,4'd1,8'h44,1'b1,1'b1},
        {1'b1,1'b1,4'd7,8'h88, 1'b1,1'b1,4'd1,8'h44,1'b1,1'b1},
        {1'b1,1'b0,4'd2,8'h00, 1'b1,1'b0,4'd0,8'h00,1'b0,1'b0},
        {1'b1,1'b0,4'd2,8'h00, 1'b0,1'b0,4'd0,8'h00,1'b0,1'b0},
        {1'b1,1'b1,4'd5,8'hAA, 1'b0,1'b0,4'd0,8'h00,1'b1,1'b0},
        {1'b0,1'b0,4'd0,8'h00, 1'b0,1'b0,4'd0,8'h00,1'b1,1'b0},
        {1'b1,1'b1,4'd5,8'hBB, 1'b1,1'b1,4'd5,8'hAA,1'b0,1'b1},
        {1'b0,1'b0,4'd0,8'h00, 1'b0,1'b1,4'd5,8'hAA,1'b0,1'b1},
        {1'b1,1'b1,4'd5,8'hCC, 1'b1,1'b0,4'd0,8'h00,1'b1,1'b0},
        {1'b0,1'b0,4'd0,8'h00, 1'b0,1'b0,4'd0,8'h00,1'b1,1'b0}
    };

    string tag [NV];

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic c, input logic [3:0] b, input logic [7:0] a);
        cmd_valid  = v;
        cmd_is_col = c;
        cmd_bank   = b;
        cmd_col    = a;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic       h0_valid;
        logic [1:0] h0_quad;
        h0_valid = 1'b0;
        h0_quad  = '0;
        tag = '{"R2","R4","R3","R5","R9","R9","R6","R6","R3","R5","R6","R6",
                "R12","R6","R5","R3","R3","R5","R12","R6","R8","R5","R12"};

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "cmd_err in reset", cmd_err, 0);
        chk("R1", "dq_valid in reset", dq_valid, 0);
        chk("R1", "dq_half in reset", dq_half, 0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            logic [29:0] v;
            v = VEC[k];
            drive(v[29], v[28], v[27:24], v[23:16]);
            @(posedge clk);
            @(negedge clk);
            chk({tag[k], " R11"}, "cmd_err", cmd_err, v[15]);
            chk("R8", "dq_valid", dq_valid, v[14]);
            chk("R8", "dq_bank", dq_bank, v[13:10]);
            chk("R8", "dq_col", dq_col, v[9:2]);
            chk("R7", "dq_half", dq_half, v[1]);
            chk("R8", "dq_grp", dq_grp, v[0]);
            // R10: edges k+1 even are slot boundaries; compare the halves of each interval
            if (((k + 1) % 2) == 0) begin
                if (!dq_half) begin
                    h0_valid = dq_valid;
                    h0_quad  = dq_bank[3:2];
                end else if (dq_valid && h0_valid) begin
                    chk("R10", "quadrants of one interval differ", int'(h0_quad != dq_bank[3:2]), 1);
                end
            end
        end

        // R1: reset during operation clears outputs and closes every bank
        drive(1'b1, 1'b0, 4'd0, 8'h00);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "dq_valid after reset", dq_valid, 0);
        chk("R1", "cmd_err after reset", cmd_err, 0);
        chk("R1", "dq_half after reset", dq_half, 0);
        drive(1'b1, 1'b1, 4'd0, 8'h12);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "column to closed bank after reset", cmd_err, 1);
        drive(1'b1, 1'b0, 4'd12, 8'h00);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "activate with cleared row timer", cmd_err, 0);
        drive(1'b1, 1'b1, 4'd13, 8'h01);
        @(posedge clk);
        @(negedge clk);
        chk("R5", "column to bank not activated", cmd_err, 1);
        drive(1'b1, 1'b1, 4'd12, 8'h02);
        @(posedge clk);
        @(negedge clk);
        chk("R5", "column to activated bank", cmd_err, 0);
        drive(1'b0, 1'b0, 4'd0, 8'h00);
        @(posedge clk);
        @(negedge clk);
        chk("R11", "error pulse lasts one cycle", cmd_err, 0);

        finish_run();
    end
endmodule